// File: doc/BRIEF.md
# Sixteen-Beam Square-Array Transform Beamformer

This block turns the sixteen complex samples that a 4x4 square antenna array delivers for one channel into sixteen fixed beams. It applies a two-dimensional 4-point discrete Fourier transform. The first pass transforms along each row of the array and the second pass transforms down each column. Every 4-point twiddle is one of +1, -1, +j or -j, so the datapath uses only adders, subtractors and swaps of the real and imaginary parts. There are no multipliers anywhere in it.

Element samples arrive one per valid cycle, and a start marker tags element 0 of each frame. When the sixteenth element has been accepted, the block computes every beam in one step. It scales each result by a per-frame right shift and saturates it, then streams the beams out in ascending order over sixteen consecutive cycles. Frames may follow each other with no idle cycles, which keeps the beam stream continuous. The block's ports match those of a general weighted-sum beamformer, so the two can replace each other in the same slot.

Top module: `beam_fft4x4`

## Requirements
- R1: After reset, `out_valid` and `out_first` are low until a complete frame has been accepted.
- R2: Capture of a frame begins only on a cycle where `in_valid` and `in_start` are both high. Valid samples without a start marker that arrive while no frame is open are ignored and produce no output.
- R3: A start marker that arrives in the middle of a frame discards the partial frame. That sample becomes element 0 of a new frame.
- R4: Cycles with `in_valid` low inside a frame are stalls. The next valid sample continues the frame at the next element index.
- R5: The k-th accepted sample of a frame (k = 0..15) is element e = k, at row r = e/4 and column c = e%4. Beam b = 4*v + u holds the sum over all elements of x(r,c)·W^(u·c + v·r), where W = -j. So u is the bin across a row and v is the bin down a column.
- R6: Beam 0 appears two cycles after the cycle that presented the sixteenth element. `out_valid` then stays high for 16 consecutive cycles, and `out_beam` counts 0 to 15 in that time. `out_first` is high only while beam 0 is shown.
- R7: Each output equals floor(sum / 2^s). The shift s is `in_scale` clamped to at most 4, taken from the start-marked sample of that frame.
- R8: A scaled result above 524287 is output as 524287, and one below -524288 is output as -524288.
- R9: Changing `in_scale` after the start-marked sample has no effect on the frame already open.
- R10: Frames presented back to back with no idle cycles give an uninterrupted beam stream. In that case `out_valid` stays high across frame boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Element sample present |
| in_start | input | 1 | Marks element 0 of a frame |
| in_re | input | 20 | Element sample, real part, signed |
| in_im | input | 20 | Element sample, imaginary part, signed |
| in_scale | input | 3 | Output right shift, captured with the start marker |
| out_valid | output | 1 | Beam sample present |
| out_first | output | 1 | Beam 0 of a frame |
| out_beam | output | 4 | Index of the beam being shown |
| out_re | output | 20 | Beam sample, real part, signed |
| out_im | output | 20 | Beam sample, imaginary part, signed |

## Verification
The assertions check several properties on every cycle. A frame opens only on a start marker, and a restart always resets the element index to 1. Stalls leave the index unchanged. A completed frame produces beam 0 exactly one cycle after completion, the beam index climbs one step at a time, and the captured shift never exceeds 4.

Other properties can only be shown by the bench's scenarios. These include the transform values themselves, the beam ordering, floor rounding under each shift, saturation at both rails, the indifference to late scale changes and to orphan samples, and the seamless handover between back-to-back frames. For these the bench compares every output cycle against a reference model that sums over the 4x4 grid.

// File: rtl/bf_pkg.sv
package bf_pkg;
  localparam int unsigned BF_SIDE  = 4;
  localparam int unsigned BF_CELLS = BF_SIDE * BF_SIDE;
  typedef logic [$clog2(BF_CELLS)-1:0] cell_idx_t;
endpackage

// File: rtl/bf_collect.sv
module bf_collect
  import bf_pkg::*;
#(
  parameter int DW    = 20,
  parameter int SHW   = 3,
  parameter int MAXSH = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_start,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  input  logic [SHW-1:0]       in_scale,
  output logic signed [DW-1:0] grid_re [BF_CELLS],
  output logic signed [DW-1:0] grid_im [BF_CELLS],
  output logic                 frame_done,
  output logic [SHW-1:0]       frame_shift
);
  localparam cell_idx_t LAST = cell_idx_t'(BF_CELLS - 1);

  cell_idx_t idx;
  logic      open_q;

  wire take_start = in_valid && in_start;
  wire take_next  = in_valid && !in_start && open_q;
  wire closing    = take_next && (idx == LAST);

  function automatic logic [SHW-1:0] clamp_shift(input logic [SHW-1:0] s);
    return (s > SHW'(MAXSH)) ? SHW'(MAXSH) : s;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      idx         <= '0;
      open_q      <= 1'b0;
      frame_done  <= 1'b0;
      frame_shift <= '0;
    end else begin
      frame_done <= closing;
      if (take_start) begin
        idx         <= cell_idx_t'(1);
        open_q      <= 1'b1;
        frame_shift <= clamp_shift(in_scale);
      end else if (take_next) begin
        idx <= idx + cell_idx_t'(1);
        if (closing) open_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take_start) begin
      grid_re[0] <= in_re;
      grid_im[0] <= in_im;
    end else if (take_next) begin
      grid_re[idx] <= in_re;
      grid_im[idx] <= in_im;
    end
  end

  AST_OPEN_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    $rose(open_q) |-> $past(in_valid && in_start)); // R2
  AST_RESTART_AT_ONE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_start) |=> (open_q && idx == cell_idx_t'(1))); // R3
  AST_STALL_KEEPS_INDEX: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(idx)); // R4
endmodule

// File: rtl/bf_dft4.sv
module bf_dft4 #(
  parameter int IW = 20,
  localparam int OW = IW + 2
) (
  input  logic signed [IW-1:0] x_re [4],
  input  logic signed [IW-1:0] x_im [4],
  output logic signed [OW-1:0] y_re [4],
  output logic signed [OW-1:0] y_im [4]
);
  logic signed [OW-1:0] er [4];
  logic signed [OW-1:0] ei [4];
  logic signed [OW-1:0] sum_ac_r, sum_ac_i, sum_bd_r, sum_bd_i;
  logic signed [OW-1:0] dif_ac_r, dif_ac_i, dif_bd_r, dif_bd_i;

  function automatic logic signed [OW-1:0] widen(input logic signed [IW-1:0] v);
    return {{(OW-IW){v[IW-1]}}, v};
  endfunction

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      er[i] = widen(x_re[i]);
      ei[i] = widen(x_im[i]);
    end
    sum_ac_r = er[0] + er[2];
    sum_ac_i = ei[0] + ei[2];
    sum_bd_r = er[1] + er[3];
    sum_bd_i = ei[1] + ei[3];
    dif_ac_r = er[0] - er[2];
    dif_ac_i = ei[0] - ei[2];
    dif_bd_r = er[1] - er[3];
    dif_bd_i = ei[1] - ei[3];
    y_re[0] = sum_ac_r + sum_bd_r;
    y_im[0] = sum_ac_i + sum_bd_i;
    y_re[1] = dif_ac_r + dif_bd_i;
    y_im[1] = dif_ac_i - dif_bd_r;
    y_re[2] = sum_ac_r - sum_bd_r;
    y_im[2] = sum_ac_i - sum_bd_i;
    y_re[3] = dif_ac_r - dif_bd_i;
    y_im[3] = dif_ac_i + dif_bd_r;
  end
endmodule

// File: rtl/bf_emit.sv
module bf_emit
  import bf_pkg::*;
#(
  parameter int AW    = 24,
  parameter int DW    = 20,
  parameter int SHW   = 3,
  parameter int MAXSH = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [SHW-1:0]       shift,
  input  logic signed [AW-1:0] beam_re [BF_CELLS],
  input  logic signed [AW-1:0] beam_im [BF_CELLS],
  output logic                 out_valid,
  output logic                 out_first,
  output logic [$clog2(BF_CELLS)-1:0] out_beam,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im
);
  localparam logic signed [AW-1:0] SAT_HI = AW'((2 ** (DW - 1)) - 1);
  localparam logic signed [AW-1:0] SAT_LO = ~SAT_HI;
  localparam cell_idx_t LAST = cell_idx_t'(BF_CELLS - 1);

  logic signed [DW-1:0] bank_re [BF_CELLS];
  logic signed [DW-1:0] bank_im [BF_CELLS];
  cell_idx_t cnt;
  logic      run_q;

  function automatic logic signed [DW-1:0] scale_sat(
    input logic signed [AW-1:0] x, input logic [SHW-1:0] s);
    logic signed [AW-1:0] t;
    t = x >>> s;
    if (t > SAT_HI) return SAT_HI[DW-1:0];
    if (t < SAT_LO) return SAT_LO[DW-1:0];
    return t[DW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt   <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      cnt <= cnt + cell_idx_t'(1);
      if (cnt == LAST) run_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      for (int b = 0; b < BF_CELLS; b++) begin
        bank_re[b] <= scale_sat(beam_re[b], shift);
        bank_im[b] <= scale_sat(beam_im[b], shift);
      end
    end
  end

  assign out_valid = run_q;
  assign out_first = run_q && (cnt == '0);
  assign out_beam  = cnt;
  assign out_re    = bank_re[cnt];
  assign out_im    = bank_im[cnt];

  AST_BEAM_STEPS_UP: assert property (@(posedge clk) disable iff (rst)
    (run_q && cnt != LAST && !load) |=> (run_q && cnt == $past(cnt) + cell_idx_t'(1))); // R6
  AST_SHIFT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    load |-> (shift <= SHW'(MAXSH))); // R7
endmodule

// File: rtl/beam_fft4x4.sv
module beam_fft4x4
  import bf_pkg::*;
#(
  parameter int DW    = 20,
  parameter int SHW   = 3,
  parameter int MAXSH = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_start,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  input  logic [SHW-1:0]       in_scale,
  output logic                 out_valid,
  output logic                 out_first,
  output logic [3:0]           out_beam,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im
);
  localparam int S1W = DW + 2;
  localparam int S2W = DW + 4;

  logic signed [DW-1:0]  grid_re [BF_CELLS];
  logic signed [DW-1:0]  grid_im [BF_CELLS];
  logic signed [S1W-1:0] row_re  [BF_CELLS];
  logic signed [S1W-1:0] row_im  [BF_CELLS];
  logic signed [S2W-1:0] beam_re [BF_CELLS];
  logic signed [S2W-1:0] beam_im [BF_CELLS];
  logic                  frame_done;
  logic [SHW-1:0]        frame_shift;

  bf_collect #(.DW(DW), .SHW(SHW), .MAXSH(MAXSH)) u_collect (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
    .in_re(in_re), .in_im(in_im), .in_scale(in_scale),
    .grid_re(grid_re), .grid_im(grid_im),
    .frame_done(frame_done), .frame_shift(frame_shift)
  );

  // First pass: along each row; bin u lands at index 4*r + u.
  for (genvar r = 0; r < BF_SIDE; r++) begin : g_rows
    logic signed [DW-1:0]  xr [4];
    logic signed [DW-1:0]  xi [4];
    logic signed [S1W-1:0] yr [4];
    logic signed [S1W-1:0] yi [4];
    for (genvar c = 0; c < BF_SIDE; c++) begin : g_tap
      assign xr[c] = grid_re[BF_SIDE*r + c];
      assign xi[c] = grid_im[BF_SIDE*r + c];
      assign row_re[BF_SIDE*r + c] = yr[c];
      assign row_im[BF_SIDE*r + c] = yi[c];
    end
    bf_dft4 #(.IW(DW)) u_dft (.x_re(xr), .x_im(xi), .y_re(yr), .y_im(yi));
  end

  // Second pass: down each column of row-pass bins; bin v lands at 4*v + u.
  for (genvar u = 0; u < BF_SIDE; u++) begin : g_cols
    logic signed [S1W-1:0] xr [4];
    logic signed [S1W-1:0] xi [4];
    logic signed [S2W-1:0] yr [4];
    logic signed [S2W-1:0] yi [4];
    for (genvar v = 0; v < BF_SIDE; v++) begin : g_tap
      assign xr[v] = row_re[BF_SIDE*v + u];
      assign xi[v] = row_im[BF_SIDE*v + u];
      assign beam_re[BF_SIDE*v + u] = yr[v];
      assign beam_im[BF_SIDE*v + u] = yi[v];
    end
    bf_dft4 #(.IW(S1W)) u_dft (.x_re(xr), .x_im(xi), .y_re(yr), .y_im(yi));
  end

  bf_emit #(.AW(S2W), .DW(DW), .SHW(SHW), .MAXSH(MAXSH)) u_emit (
    .clk(clk), .rst(rst), .load(frame_done), .shift(frame_shift),
    .beam_re(beam_re), .beam_im(beam_im),
    .out_valid(out_valid), .out_first(out_first), .out_beam(out_beam),
    .out_re(out_re), .out_im(out_im)
  );

  AST_DONE_STARTS_STREAM: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> (out_valid && out_first)); // R6
endmodule

// File: tb/beam_fft4x4_test.sv
module beam_fft4x4_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_start = 1'b0;
  logic signed [19:0] in_re = '0, in_im = '0;
  logic [2:0] in_scale = '0;
  logic out_valid, out_first;
  logic [3:0] out_beam;
  logic signed [19:0] out_re, out_im;

  always #5 clk = ~clk;

  beam_fft4x4 uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
    .in_re(in_re), .in_im(in_im), .in_scale(in_scale),
    .out_valid(out_valid), .out_first(out_first), .out_beam(out_beam),
    .out_re(out_re), .out_im(out_im)
  );

  int n_checks = 0, n_fail = 0;
  string tag = "R1";
  bit cmp_en = 1'b0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", rq, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  longint m_xr [16], m_xi [16];
  longint m_br [16], m_bi [16];
  int m_idx = 0, m_shift = 0, m_cnt = 0;
  bit m_open = 0, m_done = 0, m_valid = 0;

  function automatic longint sat20(input longint v);
    if (v > 524287) return 524287;
    if (v < -524288) return -524288;
    return v;
  endfunction

  task automatic model_transform();
    for (int b = 0; b < 16; b++) begin
      longint sr = 0, si = 0;
      for (int e = 0; e < 16; e++) begin
        int p;
        p = ((b % 4) * (e % 4) + (b / 4) * (e / 4)) % 4;
        case (p)
          0: begin sr += m_xr[e]; si += m_xi[e]; end
          1: begin sr += m_xi[e]; si -= m_xr[e]; end
          2: begin sr -= m_xr[e]; si -= m_xi[e]; end
          default: begin sr -= m_xi[e]; si += m_xr[e]; end
        endcase
      end
      m_br[b] = sat20(sr >>> m_shift);
      m_bi[b] = sat20(si >>> m_shift);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_open = 0; m_done = 0; m_valid = 0; m_idx = 0; m_cnt = 0; m_shift = 0;
    end else begin
      if (m_done) begin
        model_transform();
        m_valid = 1; m_cnt = 0;
      end else if (m_valid) begin
        if (m_cnt == 15) m_valid = 0;
        m_cnt = (m_cnt + 1) % 16;
      end
      m_done = 0;
      if (in_valid && in_start) begin
        m_xr[0] = in_re; m_xi[0] = in_im;
        m_idx = 1; m_open = 1;
        m_shift = (in_scale > 4) ? 4 : int'(in_scale);
      end else if (in_valid && m_open) begin
        m_xr[m_idx] = in_re; m_xi[m_idx] = in_im;
        if (m_idx == 15) begin m_open = 0; m_done = 1; end
        m_idx = (m_idx + 1) % 16;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(out_valid == m_valid, tag, "out_valid", out_valid, m_valid);
      if (m_valid && out_valid) begin
        chk(out_beam == m_cnt, tag, "out_beam", out_beam, m_cnt);
        chk(out_first == (m_cnt == 0), tag, "out_first", out_first, m_cnt == 0);
        chk(out_re == m_br[m_cnt], tag, $sformatf("beam %0d re", m_cnt), out_re, m_br[m_cnt]);
        chk(out_im == m_bi[m_cnt], tag, $sformatf("beam %0d im", m_cnt), out_im, m_bi[m_cnt]);
      end
    end
  end

  longint fr_re [16], fr_im [16];

  task automatic fill_random();
    for (int k = 0; k < 16; k++) begin
      fr_re[k] = longint'($signed(20'($urandom)));
      fr_im[k] = longint'($signed(20'($urandom)));
    end
  endtask

  task automatic fill_const(input longint re, input longint im);
    for (int k = 0; k < 16; k++) begin fr_re[k] = re; fr_im[k] = im; end
  endtask

  // Drives one frame; gap inserts that many idle cycles after each sample
  task automatic drive_frame(input int sc, input int sc_late, input int gap, input int upto);
    for (int k = 0; k < upto; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_start = (k == 0);
      in_re = 20'(fr_re[k]);
      in_im = 20'(fr_im[k]);
      in_scale = (k == 0) ? 3'(sc) : 3'(sc_late);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        in_valid = 1'b0; in_start = 1'b0;
        in_re = 20'($urandom); in_im = 20'($urandom);
      end
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0; in_start = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(out_first == 1'b0, "R1", "out_first after reset", out_first, 0);
    cmp_en = 1'b1;

    // R2: orphan samples with no start marker
    tag = "R2";
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_start = 1'b0;
      in_re = 20'($urandom); in_im = 20'($urandom);
    end
    idle(20);
    chk(out_valid == 1'b0, "R2", "no output from orphan samples", out_valid, 0);

    // R5 / R6: single impulses and a ramp, shift 0
    tag = "R5";
    for (int e = 0; e < 16; e += 5) begin
      fill_const(0, 0);
      fr_re[e] = 1000; fr_im[e] = -300;
      drive_frame(0, 0, 0, 16);
      idle(20);
    end
    for (int k = 0; k < 16; k++) begin fr_re[k] = 100 * k; fr_im[k] = 7 - 3 * k; end
    tag = "R6";
    drive_frame(0, 0, 0, 16);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R6", "no beam one cycle after last element", out_valid, 0);
    @(negedge clk);
    chk(out_valid && out_first, "R6", "beam 0 two cycles after last element",
        out_valid && out_first, 1);
    idle(20);

    // R4: stalls inside a frame
    tag = "R4";
    fill_random();
    drive_frame(1, 1, 2, 16);
    idle(20);

    // R3: restart after a partial frame
    tag = "R3";
    fill_random();
    drive_frame(2, 2, 0, 7);
    fill_random();
    drive_frame(0, 0, 0, 16);
    idle(20);

    // R7 / R10: back-to-back frames, every shift code including clamped ones
    tag = "R10";
    for (int s = 0; s < 8; s++) begin
      fill_random();
      drive_frame(s, s, 0, 16);
    end
    idle(20);
    tag = "R7";
    for (int k = 0; k < 16; k++) begin fr_re[k] = -5 - k; fr_im[k] = 3 * k - 17; end
    drive_frame(3, 3, 0, 16);
    idle(20);

    // R8: saturation at both rails, and exact fit with shift 4
    tag = "R8";
    fill_const(524287, -524288);
    drive_frame(0, 0, 0, 16);
    idle(20);
    drive_frame(4, 4, 0, 16);
    idle(20);
    fill_const(-524288, 524287);
    drive_frame(1, 1, 0, 16);
    idle(20);

    // R9: scale changed after the start sample
    tag = "R9";
    fill_random();
    drive_frame(0, 4, 0, 16);
    idle(20);
    fill_random();
    drive_frame(4, 0, 1, 16);
    idle(20);

    cmp_en = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule